// File: doc/BRIEF.md
# Decimal Product Display Unit

This block takes two small unsigned operands, multiplies them, and presents the result as three decimal digits on seven-segment outputs. A single-cycle start strobe captures the operands and their binary product. A serial shift-and-add-3 converter then turns the product into hundreds, tens and ones digits. Each digit goes through a shared ten-entry segment decoder, so the number of segment patterns does not depend on the number of possible products.

The raw product is available as soon as the start strobe is taken. The decimal digits follow a fixed number of cycles later and are marked by a one-cycle valid pulse. Digits and segments keep their value until the next conversion completes. A start strobe that arrives while a conversion is running is ignored.

Top module: `dec_product_display`

## Requirements
- R1: On an accepted start (start high while no conversion runs), `product` takes the value op_a × op_b at that clock edge and holds it until the next accepted start.
- R2: `valid` goes high for exactly one cycle. It is high in the 8th cycle after the edge that accepted start, and at no other time.
- R3: When `valid` is high, and from then on until the next completion, the displayed digits are: hundreds = product / 100, tens = (product mod 100) / 10, ones = product mod 10. The largest product is 225.
- R4: The segment vectors are active high. Bit 0 is segment a and bit 6 is segment g. The patterns for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R5: The hundreds digit is blanked (all segments off, 0x00) when it is zero. The tens and ones digits always show their value, including 0.
- R6: A start strobe that arrives while a conversion is running is ignored. `product` is unchanged, no extra `valid` pulse appears, and the result shown belongs to the operands of the accepted start.
- R7: A synchronous active-high reset clears `valid`, `product` and the digits. After reset the ones and tens show 0 and the hundreds is blank. A reset during a conversion aborts it, so no `valid` follows.
- R8: A start given in the same cycle that `valid` is high is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, one cycle |
| op_a | input | 4 | First unsigned operand |
| op_b | input | 4 | Second unsigned operand |
| seg_hund | output | 7 | Hundreds digit segments, bit 0 = a |
| seg_tens | output | 7 | Tens digit segments, bit 0 = a |
| seg_ones | output | 7 | Ones digit segments, bit 0 = a |
| product | output | 8 | Binary product captured at start |
| valid | output | 1 | One-cycle pulse when the digits are updated |

## Verification
The directed operand pairs are chosen to separate the digit positions:
- 0×0 exercises the all-blank-hundreds case.
- 10×10 = 100 gives zero tens and ones under a nonzero hundreds digit.
- 15×15 = 225 is the largest value.
- Single-digit and two-digit products such as 3×3 and 7×9 show whether blanking is applied to the hundreds position only.

Seeded random pairs cover the other carry patterns of the add-3 correction. Further sequences test the start-strobe handling:
- a start injected during a running conversion;
- a start given back-to-back in the cycle of the valid pulse;
- a reset in the middle of a conversion.

These separate correct accept-and-ignore behaviour from a converter that restarts or loses its result.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    localparam int OP_W   = 4;
    localparam int PROD_W = 2 * OP_W;
    localparam int NDIG   = 3;
    localparam int DIG_W  = 4;
    localparam int SEG_W  = 7;

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Active-high segments: bit 0 = a ... bit 6 = g.
    // Codes 10 to 15 are not decimal digits and are shown dark.
    function automatic seg_t digit_to_seg(digit_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mpd_mult.sv
module mpd_mult #(
    parameter int OP_W = 4,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] p
);
    always_comb begin
        p = PROD_W'(a) * PROD_W'(b);
    end
endmodule

// File: rtl/mpd_bcd_conv.sv
module mpd_bcd_conv #(
    parameter int BIN_W = 8,
    parameter int NDIG  = 3,
    localparam int CNT_W = $clog2(BIN_W + 1),
    localparam int WRK_W = NDIG * 4 + BIN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [BIN_W-1:0]     bin,
    output logic [NDIG-1:0][3:0] digits,
    output logic                 busy,
    output logic                 done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIN_W - 1);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [CNT_W-1:0]     cnt;
        logic [BIN_W-1:0]     sh;
        logic [NDIG-1:0][3:0] work;
        logic [NDIG-1:0][3:0] res;
    } conv_st_t;

    conv_st_t st_d, st_q;
    logic [NDIG-1:0][3:0] adj;
    logic [WRK_W-1:0]     shifted;

    // One add-3 correction cell for each decimal digit.
    for (genvar g = 0; g < NDIG; g++) begin : g_adj
        always_comb begin
            adj[g] = (st_q.work[g] >= 4'd5) ? st_q.work[g] + 4'd3 : st_q.work[g];
        end
    end

    always_comb begin
        shifted = {adj, st_q.sh} << 1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.work = shifted[WRK_W-1:BIN_W];
            st_d.sh   = shifted[BIN_W-1:0];
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = shifted[WRK_W-1:BIN_W];
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = bin;
            st_d.work = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign digits = st_q.res;
    assign busy   = st_q.busy;
    assign done   = st_q.done;
endmodule

// File: rtl/mpd_seg_dec.sv
module mpd_seg_dec
    import mpd_pkg::*;
(
    input  digit_t digit,
    input  logic   blank,
    output seg_t   seg
);
    always_comb begin
        seg = blank ? '0 : digit_to_seg(digit);
    end
endmodule

// File: rtl/dec_product_display.sv
module dec_product_display
    import mpd_pkg::*;
#(
    parameter int OPW = OP_W,
    localparam int PW = 2 * OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic [6:0]     seg_hund,
    output logic [6:0]     seg_tens,
    output logic [6:0]     seg_ones,
    output logic [PW-1:0]  product,
    output logic           valid
);
    typedef struct packed {
        logic [PW-1:0] prod;
    } top_st_t;

    top_st_t top_d, top_q;
    logic [PW-1:0]        prod_comb;
    logic                 conv_busy;
    logic                 conv_done;
    logic                 accept;
    logic [NDIG-1:0][3:0] bcd_digits;
    logic [NDIG-1:0][6:0] segs;

    mpd_mult #(.OP_W(OPW)) u_mult (
        .a (op_a),
        .b (op_b),
        .p (prod_comb)
    );

    assign accept = start && !conv_busy;

    always_comb begin
        top_d = top_q;
        if (accept) top_d.prod = prod_comb;
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    mpd_bcd_conv #(.BIN_W(PW), .NDIG(NDIG)) u_conv (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .bin    (prod_comb),
        .digits (bcd_digits),
        .busy   (conv_busy),
        .done   (conv_done)
    );

    // Only the most significant digit is blanked when it is zero.
    for (genvar g = 0; g < NDIG; g++) begin : g_seg
        logic blank;
        assign blank = (g == NDIG - 1) && (bcd_digits[g] == 4'd0);
        mpd_seg_dec u_dec (
            .digit (bcd_digits[g]),
            .blank (blank),
            .seg   (segs[g])
        );
    end

    assign seg_ones = segs[0];
    assign seg_tens = segs[1];
    assign seg_hund = segs[NDIG-1];
    assign product  = top_q.prod;
    assign valid    = conv_done;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          valid,
    input logic [PW-1:0] product,
    input logic [11:0]   digits,
    input logic [6:0]    seg_hund
);
    localparam int LAT   = PW + 1;
    localparam int LAT_W = $clog2(LAT + 2);

    logic [LAT_W-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst)                                  lat <= '0;
        else if (start && !busy)                  lat <= LAT_W'(1);
        else if (lat != '0 && lat < LAT_W'(LAT + 1)) lat <= lat + 1'b1;
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        valid |-> (lat == LAT_W'(LAT)));

    a_r3_digits_match: assert property (@(posedge clk) disable iff (rst)
        valid |-> (int'(digits[11:8]) * 100 + int'(digits[7:4]) * 10
                   + int'(digits[3:0]) == int'(product)));

    a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
        valid |-> (digits[11:8] <= 4'd9 && digits[7:4] <= 4'd9 && digits[3:0] <= 4'd9));

    a_r5_hund_blank: assert property (@(posedge clk) disable iff (rst)
        (digits[11:8] == 4'd0) |-> (seg_hund == 7'h00));

    a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(product));

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!valid && product == '0 && digits == 12'h000));
endmodule

bind dec_product_display mpd_checker #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (conv_busy),
    .valid    (valid),
    .product  (product),
    .digits   (bcd_digits),
    .seg_hund (seg_hund)
);

// File: tb/tb_dec_product_display.sv
module tb_dec_product_display;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [6:0] seg_hund, seg_tens, seg_ones;
    logic [7:0] product;
    logic       valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dec_product_display dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_a     (op_a),
        .op_b     (op_b),
        .seg_hund (seg_hund),
        .seg_tens (seg_tens),
        .seg_ones (seg_ones),
        .product  (product),
        .valid    (valid)
    );

    function automatic int pat(int d);
        case (d)
            0: return 'h3F;  1: return 'h06;  2: return 'h5B;  3: return 'h4F;
            4: return 'h66;  5: return 'h6D;  6: return 'h7D;  7: return 'h07;
            8: return 'h7F;  9: return 'h6F;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R3, R4, R5: expected display for a given product value
    task automatic check_display(input string req, input int p);
        int h = p / 100;
        int t = (p % 100) / 10;
        int o = p % 10;
        check({req, " R5 hundreds"}, int'(seg_hund), (h == 0) ? 0 : pat(h));
        check({req, " R4 tens"},     int'(seg_tens), pat(t));
        check({req, " R4 ones"},     int'(seg_ones), pat(o));
    endtask

    // Called at a negedge: pulse start for one cycle.
    task automatic pulse_start(input int a, input int b);
        op_a  = 4'(a);
        op_b  = 4'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 product", int'(product), a * b);
    endtask

    // Waits for the result; ends at the negedge where valid is high.
    task automatic wait_result(input int a, input int b, input bit inject);
        for (int k = 1; k <= 8; k++) begin
            if (inject && k == 3) begin
                op_a  = ~4'(a);
                op_b  = 4'(b) + 4'd1;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (inject && k == 3)
                check("R6 product kept", int'(product), a * b);
            check("R2 valid timing", int'(valid), (k == 8) ? 1 : 0);
        end
        check_display("R3 result", a * b);
    endtask

    task automatic conv(input int a, input int b, input bit inject);
        pulse_start(a, b);
        wait_result(a, b, inject);
        @(negedge clk);
        check("R2 valid drop", int'(valid), 0);
        check_display("R3 held", a * b);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        check("R7 valid", int'(valid), 0);
        check("R7 product", int'(product), 0);
        check_display("R7 reset", 0);

        // Directed corners
        conv(0, 0, 1'b0);
        conv(15, 15, 1'b0);
        conv(10, 10, 1'b0);
        conv(3, 3, 1'b0);
        conv(7, 9, 1'b0);
        conv(1, 1, 1'b0);
        conv(8, 12, 1'b0);

        // R6 start during conversion is ignored
        conv(13, 11, 1'b1);
        conv(2, 5, 1'b1);

        // R8 back-to-back start in the valid cycle
        pulse_start(14, 9);
        wait_result(14, 9, 1'b0);
        pulse_start(6, 4);
        check("R8 accepted", int'(product), 24);
        wait_result(6, 4, 1'b0);
        @(negedge clk);
        check("R8 valid drop", int'(valid), 0);

        // R7 reset in the middle of a conversion
        pulse_start(9, 9);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R7 aborted", int'(valid), 0);
        end
        check("R7 product cleared", int'(product), 0);
        check_display("R7 cleared", 0);

        // Random operand pairs
        for (int n = 0; n < 40; n++) begin
            int a = int'($urandom() % 16);
            int b = int'($urandom() % 16);
            conv(a, b, (n % 7) == 3);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule